// File: doc/BRIEF.md
# Event-Driven Output Set/Clear Resolver

This block holds the state of a bank of timer-driven output lines. Each clock cycle it receives a vector of active events. For every output it combines that vector with two stored masks, one for set and one for clear, to form a set request and a clear request. It then updates that output's bit in the output register. The counters, match logic and event generation sit elsewhere. Only the two count-down flags, one for the low (or unified) counter half and one for the high half, come into this block.

Two per-output policies shape the update. A direction mode can exchange the meaning of set and clear while a selected counter half counts down. This gives centre-aligned waveforms from a single pair of events. A conflict mode decides what a cycle with both a set and a clear request does: hold, set, clear or invert. Inverting lets a single event toggle an output when that event appears in both of its masks. Software configures the block through a plain single-cycle register write port.

Top module: `evo_out_bank`

## Requirements
- R1: Reset (active-low `rst_n`) drives every output to 0 and every configuration field and mask to 0, so that after reset a cycle with both requests leaves the outputs unchanged.
- R2: With no direction swap active, an output whose set mask shares a bit with `evt_active` (and whose clear mask does not) becomes 1 on the next rising edge, and one with only a clear request becomes 0.
- R3: An output with neither request keeps its value.
- R4: Direction mode 1 swaps set and clear while `cnt_lo_down` is 1. The mode ignores `cnt_hi_down`.
- R5: Direction mode 2 swaps set and clear while `cnt_hi_down` is 1. The mode ignores `cnt_lo_down`.
- R6: Direction mode 0, and the reserved value 3, never swap, whatever the count-down flags are.
- R7: When both requests are present, the conflict mode decides the result: 0 holds, 1 sets, 2 clears, 3 inverts the current value.
- R8: While a swap is active, conflict modes 1 and 2 follow it: 1 clears and 2 sets. Modes 0 and 3 are unaffected.
- R9: Writes with `cfg_wr_en` high store `cfg_wdata` at `cfg_addr`. Address 0 holds the direction fields and address 1 the conflict fields, with output n in bits [2n+1:2n]. Address 2+n holds output n's set mask and address 2+N_OUT+n its clear mask, both in the low N_EVT bits. Each output uses only its own fields and masks.
- R10: One event enabled in both masks of an output whose conflict mode is 3 toggles that output on each cycle the event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_active | input | N_EVT | Events active in this cycle |
| cnt_lo_down | input | 1 | Low or unified counter is counting down |
| cnt_hi_down | input | 1 | High counter is counting down |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(2+2*N_OUT) | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| out_state | output | N_OUT | Current output register |

## Verification
The hardest situations to reach are the cross products of a swapped direction with a simultaneous set and clear request on an output whose prior value is already known. These need the configuration, the mask pair, the count-down flags and the preceding state all in place in the right cycle. The stimulus programs fixed masks so that two event bits map directly to set and clear. Before each test cycle it drives the outputs to a chosen starting value with an unswapped single request. It then walks all 4×4×2×2×2×2 combinations of conflict mode, direction mode, flags and request pair, from both starting values, against a model. Per-output field placement is reached by writing distinct field patterns across the outputs and comparing the whole output vector.

// File: rtl/evo_pkg.sv
// Package: shared types and constants for the output set/clear resolver.
// Assumes configuration words are 32 bits and fields are 2 bits per output.
package evo_pkg;

    localparam int CFG_DW        = 32;
    localparam int FIELD_W       = 2;
    localparam int ADDR_DIR      = 0;
    localparam int ADDR_CNF      = 1;
    localparam int ADDR_SET_BASE = 2;

    typedef enum logic [1:0] {
        DIR_FIXED = 2'd0,
        DIR_LO    = 2'd1,
        DIR_HI    = 2'd2,
        DIR_RSVD  = 2'd3
    } dir_mode_e;

    typedef enum logic [1:0] {
        CNF_HOLD   = 2'd0,
        CNF_SET    = 2'd1,
        CNF_CLEAR  = 2'd2,
        CNF_INVERT = 2'd3
    } cnf_mode_e;

endpackage

// File: rtl/evo_cfg_regs.sv
// Module: configuration storage. Holds the packed direction and conflict
// words plus one set mask and one clear mask per output.
// Assumes 2*N_OUT <= 32 and N_EVT <= 32; unmapped addresses are ignored.
module evo_cfg_regs
    import evo_pkg::*;
#(
    parameter int N_OUT  = 16,
    parameter int N_EVT  = 16,
    parameter int ADDR_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [CFG_DW-1:0]                 wr_data,
    output logic [FIELD_W*N_OUT-1:0]          dir_cfg,
    output logic [FIELD_W*N_OUT-1:0]          cnf_cfg,
    output logic [N_OUT-1:0][N_EVT-1:0]       set_mask,
    output logic [N_OUT-1:0][N_EVT-1:0]       clr_mask
);

    localparam int FW            = FIELD_W * N_OUT;
    localparam int ADDR_CLR_BASE = ADDR_SET_BASE + N_OUT;

    // Direction word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_cfg <= '0;
        end else if (wr_en && (wr_addr == ADDR_W'(ADDR_DIR))) begin
            dir_cfg <= wr_data[FW-1:0];
        end
    end

    // Conflict word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnf_cfg <= '0;
        end else if (wr_en && (wr_addr == ADDR_W'(ADDR_CNF))) begin
            cnf_cfg <= wr_data[FW-1:0];
        end
    end

    for (genvar n = 0; n < N_OUT; n++) begin : g_mask
        // Set mask register for output n.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                set_mask[n] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(ADDR_SET_BASE + n))) begin
                set_mask[n] <= wr_data[N_EVT-1:0];
            end
        end

        // Clear mask register for output n.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clr_mask[n] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(ADDR_CLR_BASE + n))) begin
                clr_mask[n] <= wr_data[N_EVT-1:0];
            end
        end
    end

endmodule

// File: rtl/evo_req_combine.sv
// Module: turns the active event vector into per-output set and clear
// requests by matching it against each output's two masks.
// Assumes purely combinational use; no state.
module evo_req_combine #(
    parameter int N_OUT = 16,
    parameter int N_EVT = 16
) (
    input  logic [N_EVT-1:0]            evt,
    input  logic [N_OUT-1:0][N_EVT-1:0] set_mask,
    input  logic [N_OUT-1:0][N_EVT-1:0] clr_mask,
    output logic [N_OUT-1:0]            set_req,
    output logic [N_OUT-1:0]            clr_req
);

    for (genvar n = 0; n < N_OUT; n++) begin : g_req
        // Any matching event raises the request for output n.
        always_comb begin
            set_req[n] = |(evt & set_mask[n]);
            clr_req[n] = |(evt & clr_mask[n]);
        end
    end

endmodule

// File: rtl/evo_bit_resolve.sv
// Module: next-state logic for one output. Applies the direction swap,
// then the conflict policy when both requests are present.
// Assumes reserved direction code 3 behaves as the fixed mode.
module evo_bit_resolve
    import evo_pkg::*;
(
    input  dir_mode_e dir_mode,
    input  cnf_mode_e cnf_mode,
    input  logic      lo_down,
    input  logic      hi_down,
    input  logic      set_req,
    input  logic      clr_req,
    input  logic      cur,
    output logic      nxt
);

    logic swap;

    // Decide whether set and clear exchange roles this cycle.
    always_comb begin
        unique case (dir_mode)
            DIR_LO:  swap = lo_down;
            DIR_HI:  swap = hi_down;
            default: swap = 1'b0;
        endcase
    end

    // Compute the next output value.
    always_comb begin
        if (set_req && clr_req) begin
            unique case (cnf_mode)
                CNF_HOLD:   nxt = cur;
                CNF_SET:    nxt = ~swap;
                CNF_CLEAR:  nxt = swap;
                CNF_INVERT: nxt = ~cur;
                default:    nxt = cur;
            endcase
        end else if (set_req) begin
            nxt = ~swap;
        end else if (clr_req) begin
            nxt = swap;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/evo_out_bank.sv
// Module: top of the output set/clear resolver. Stores configuration,
// forms requests from events and registers the resolved outputs.
// Assumes N_OUT <= 16 and N_EVT <= 32 so fields fit one 32-bit word.
module evo_out_bank
    import evo_pkg::*;
#(
    parameter  int N_OUT  = 16,
    parameter  int N_EVT  = 16,
    localparam int N_ADDR = ADDR_SET_BASE + 2 * N_OUT,
    localparam int ADDR_W = $clog2(N_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_active,
    input  logic              cnt_lo_down,
    input  logic              cnt_hi_down,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [N_OUT-1:0]  out_state
);

    logic [FIELD_W*N_OUT-1:0]    dir_cfg;
    logic [FIELD_W*N_OUT-1:0]    cnf_cfg;
    logic [N_OUT-1:0][N_EVT-1:0] set_mask;
    logic [N_OUT-1:0][N_EVT-1:0] clr_mask;
    logic [N_OUT-1:0]            set_req;
    logic [N_OUT-1:0]            clr_req;
    logic [N_OUT-1:0]            out_nxt;

    evo_cfg_regs #(
        .N_OUT  (N_OUT),
        .N_EVT  (N_EVT),
        .ADDR_W (ADDR_W)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .dir_cfg  (dir_cfg),
        .cnf_cfg  (cnf_cfg),
        .set_mask (set_mask),
        .clr_mask (clr_mask)
    );

    evo_req_combine #(
        .N_OUT (N_OUT),
        .N_EVT (N_EVT)
    ) req_i (
        .evt      (evt_active),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .set_req  (set_req),
        .clr_req  (clr_req)
    );

    for (genvar n = 0; n < N_OUT; n++) begin : g_bit
        evo_bit_resolve res_i (
            .dir_mode (dir_mode_e'(dir_cfg[FIELD_W*n +: FIELD_W])),
            .cnf_mode (cnf_mode_e'(cnf_cfg[FIELD_W*n +: FIELD_W])),
            .lo_down  (cnt_lo_down),
            .hi_down  (cnt_hi_down),
            .set_req  (set_req[n]),
            .clr_req  (clr_req[n]),
            .cur      (out_state[n]),
            .nxt      (out_nxt[n])
        );
    end

    // Output state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_state <= '0;
        end else begin
            out_state <= out_nxt;
        end
    end

endmodule

// File: rtl/evo_out_bank_chk.sv
// Module: assertion checker for evo_out_bank, attached by bind below.
// Assumes it sees the top's requests and configuration words.
module evo_out_bank_chk #(
    parameter int N_OUT = 16,
    parameter int N_EVT = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_EVT-1:0]       evt_active,
    input logic                   cnt_lo_down,
    input logic                   cnt_hi_down,
    input logic [N_OUT-1:0]       out_state,
    input logic [N_OUT-1:0]       set_req,
    input logic [N_OUT-1:0]       clr_req,
    input logic [2*N_OUT-1:0]     dir_cfg,
    input logic [2*N_OUT-1:0]     cnf_cfg
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_state == '0)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_active == '0) |=> $stable(out_state)); // R3

    for (genvar n = 0; n < N_OUT; n++) begin : g_bit_chk
        AST_FIXED_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req[n] && !clr_req[n] && dir_cfg[2*n +: 2] == 2'd0)
            |=> out_state[n]); // R2

        AST_LO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req[n] && !clr_req[n] && dir_cfg[2*n +: 2] == 2'd1 && cnt_lo_down)
            |=> !out_state[n]); // R4

        AST_HI_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[n] && !set_req[n] && dir_cfg[2*n +: 2] == 2'd2 && cnt_hi_down)
            |=> out_state[n]); // R5

        AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req[n] && clr_req[n] && cnf_cfg[2*n +: 2] == 2'd0)
            |=> $stable(out_state[n])); // R7

        AST_CONFLICT_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req[n] && clr_req[n] && cnf_cfg[2*n +: 2] == 2'd3)
            |=> (out_state[n] != $past(out_state[n]))); // R10
    end

endmodule

bind evo_out_bank evo_out_bank_chk #(
    .N_OUT (N_OUT),
    .N_EVT (N_EVT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_active  (evt_active),
    .cnt_lo_down (cnt_lo_down),
    .cnt_hi_down (cnt_hi_down),
    .out_state   (out_state),
    .set_req     (set_req),
    .clr_req     (clr_req),
    .dir_cfg     (dir_cfg),
    .cnf_cfg     (cnf_cfg)
);

// File: tb/evo_out_bank_tb_top.sv
// Bench: table walk, exhaustive mode sweep against a model, then directed
// tests for reset, field placement and per-output masks.
module evo_out_bank_tb_top;

    localparam int  N_OUT    = 16;
    localparam int  N_EVT    = 16;
    localparam int  ADDR_W   = $clog2(2 + 2 * N_OUT);
    localparam int  CLR_BASE = 2 + N_OUT;
    localparam time CLK_PER  = 10ns;
    localparam int  WD_LIMIT = 100000;

    typedef struct packed {
        logic [1:0] dir;
        logic [1:0] cnf;
        logic       lo;
        logic       hi;
        logic       s;
        logic       c;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    // Sequential vectors; state starts at 0 with set mask bit0, clear mask bit1.
    localparam int NV = 14;
    localparam vec_t TABLE [NV] = '{
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 set
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 hold
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 clear
        '{2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd10}, // R10 toggle up
        '{2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 toggle down
        '{2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 swap on lo
        '{2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 ignores hi
        '{2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 swap on hi
        '{2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 mode1 clears
        '{2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 mode2 sets
        '{2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 reserved
        '{2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 set
        '{2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 clear
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7}   // R7 hold
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_EVT-1:0]  evt_active = '0;
    logic              cnt_lo_down = 1'b0;
    logic              cnt_hi_down = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [N_OUT-1:0]  out_state;

    int n_checks = 0;
    int n_errors = 0;

    evo_out_bank #(.N_OUT(N_OUT), .N_EVT(N_EVT)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_active  (evt_active),
        .cnt_lo_down (cnt_lo_down),
        .cnt_hi_down (cnt_hi_down),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .out_state   (out_state)
    );

    always #(CLK_PER / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Model of one output's next value, written from the requirements.
    function automatic logic model_next(logic [1:0] dir, logic [1:0] cnf,
                                        logic lo, logic hi, logic s, logic c,
                                        logic cur);
        logic sw;
        sw = (dir == 2'd1 && lo) || (dir == 2'd2 && hi);
        if (s && c) begin
            case (cnf)
                2'd0:    return cur;
                2'd1:    return !sw;
                2'd2:    return sw;
                default: return !cur;
            endcase
        end
        if (s) return !sw;
        if (c) return sw;
        return cur;
    endfunction

    task automatic check(input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp,
                         input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic cfg_write(input int addr, input logic [31:0] data);
        cfg_wr_en = 1'b1;
        cfg_addr  = ADDR_W'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic apply(input logic [N_EVT-1:0] evt, input logic lo, input logic hi);
        evt_active  = evt;
        cnt_lo_down = lo;
        cnt_hi_down = hi;
        @(negedge clk);
        evt_active  = '0;
        cnt_lo_down = 1'b0;
        cnt_hi_down = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_state, '0, "R1", "outputs under reset");
        rst_n = 1'b1;

        // R1: configuration reset to zero: masks empty so events do nothing.
        apply('1, 1'b0, 1'b0);
        check(out_state, '0, "R1", "empty masks after reset");

        for (int n = 0; n < N_OUT; n++) begin
            cfg_write(2 + n, 32'h1);
            cfg_write(CLR_BASE + n, 32'h2);
        end

        // R1: conflict fields zero after reset: both requests hold.
        apply(16'h1, 1'b0, 1'b0);
        apply(16'h3, 1'b0, 1'b0);
        check(out_state, '1, "R1", "conflict field reset holds");
        apply(16'h2, 1'b0, 1'b0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            cfg_write(0, {16{TABLE[i].dir}});
            cfg_write(1, {16{TABLE[i].cnf}});
            apply({14'd0, TABLE[i].c, TABLE[i].s}, TABLE[i].lo, TABLE[i].hi);
            check(out_state, {N_OUT{TABLE[i].exp}}, $sformatf("R%0d", TABLE[i].req),
                  $sformatf("table row %0d", i));
        end

        // Exhaustive sweep: R4 R5 R6 R7 R8 against the model.
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 4; k++) begin
                cfg_write(0, {16{2'(d)}});
                cfg_write(1, {16{2'(k)}});
                for (int v = 0; v < 32; v++) begin
                    logic init, lo, hi, s, c, e;
                    {init, lo, hi, s, c} = 5'(v);
                    apply(init ? 16'h1 : 16'h2, 1'b0, 1'b0);
                    apply({14'd0, c, s}, lo, hi);
                    e = model_next(2'(d), 2'(k), lo, hi, s, c, init);
                    check(out_state, {N_OUT{e}}, "R7",
                          $sformatf("sweep dir=%0d cnf=%0d v=%0d", d, k, v));
                end
            end
        end

        // R9: per-output conflict fields (out n uses n%4).
        cfg_write(0, 32'h0);
        cfg_write(1, 32'hE4E4_E4E4);
        apply(16'h2, 1'b0, 1'b0);
        apply(16'h3, 1'b0, 1'b0);
        check(out_state, 16'hAAAA, "R9", "conflict field placement");
        apply(16'h3, 1'b0, 1'b0);
        check(out_state, 16'h2222, "R9", "conflict field placement second");

        // R9: per-output set masks.
        apply(16'h2, 1'b0, 1'b0);
        for (int n = 0; n < N_OUT; n++) begin
            cfg_write(2 + n, 32'(1 << n));
            cfg_write(CLR_BASE + n, 32'h0);
        end
        apply(16'h0020, 1'b0, 1'b0);
        check(out_state, 16'h0020, "R9", "own set mask only");

        // R9 with R4: odd outputs in lo-swap mode, even outputs fixed.
        cfg_write(0, 32'h4444_4444);
        apply('1, 1'b1, 1'b0);
        check(out_state, 16'h5555, "R4", "per-output direction placement");
        apply('1, 1'b0, 1'b1);
        check(out_state, 16'hFFFF, "R4", "lo-mode ignores hi flag");

        // R3: no events keeps all outputs.
        apply('0, 1'b1, 1'b1);
        check(out_state, 16'hFFFF, "R3", "idle cycle holds");

        // R1: reset mid-run clears outputs and configuration.
        rst_n = 1'b0;
        @(negedge clk);
        check(out_state, '0, "R1", "reset mid-run");
        rst_n = 1'b1;
        apply('1, 1'b0, 1'b0);
        check(out_state, '0, "R1", "masks cleared by reset");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule